// File: doc/BRIEF.md
# Glitch-free Dual-Clock Processor Switch

This block lets one of two processors own a shared system clock. Each processor runs from its own free-running clock, and the two clocks have no fixed phase relation. A level request input, `sel_b`, says which processor should run: 0 selects processor A and 1 selects processor B. The request passes through two flip-flops clocked by the outgoing system clock. When the second flip-flop changes, the system clock output is held high. It stays high until a third flip-flop, clocked by the newly chosen clock, confirms the change. Only then does the output follow the new clock. Because of this, no short high or low pulse ever reaches the system clock.

The same request also drives the hold request of each processor. When `sel_b` first disagrees with the committed selection, both hold requests are asserted at once and asynchronously. This hold lasts until the committed selection catches up. After that, the incoming processor's hold is released on a rising edge of its own clock, and the outgoing processor stays held. A status output, `b_active`, reports that processor B's clock is the one passing to the output.

The output gate has four named phases, decoded from the committed selection (second stage) and the confirmed selection (third stage):

- `PH_RUN_A`: both stages are 0, and the output follows clock A.
- `PH_RUN_B`: both stages are 1, and the output follows clock B.
- `PH_BRIDGE_TO_B`: the committed selection is 1 and the confirmed selection is 0. The output is held high.
- `PH_BRIDGE_TO_A`: the committed selection is 0 and the confirmed selection is 1. The output is held high.

The transitions between phases are:

- `PH_RUN_A` to `PH_BRIDGE_TO_B`: the second stage rises on a system clock edge.
- `PH_BRIDGE_TO_B` to `PH_RUN_B`: the first rising edge of clock B.
- `PH_RUN_B` to `PH_BRIDGE_TO_A`: the second stage falls.
- `PH_BRIDGE_TO_A` to `PH_RUN_A`: the first rising edge of clock A.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the output follows clock A, `b_active` is 0, `hold_a` is 0 and `hold_b` is 1.
- R2: `sel_b` is sampled on rising edges of `sys_clk` into a first stage, then moved to a second stage on the next rising edge. The source leaves the old clock at that second edge.
- R3: From the second-stage change until the first rising edge of the newly selected clock, `sys_clk` stays at 1.
- R4: Outside a swap, `sys_clk` equals the selected clock. No high or low phase of `sys_clk` is ever shorter than the shorter half-period of the two input clocks.
- R5: While `sel_b` differs from the second stage, `hold_a` and `hold_b` are both 1, with no clock needed.
- R6: Once the second stage equals `sel_b`, the selected processor's hold clears on the next rising edge of its own clock. The other processor's hold stays 1. The two holds are never both 0.
- R7: `b_active` rises on the first rising edge of clock B after the second stage becomes 1. It stays 1 for as long as clock B is passed.
- R8: A switch from B back to A follows the same sequence with the stage values going from 1 to 0. After it, `b_active` is 0, `hold_a` is 0 and `hold_b` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Free-running clock of processor A |
| clk_b | input | 1 | Free-running clock of processor B, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_b | input | 1 | Requested processor: 0 = A, 1 = B |
| sys_clk | output | 1 | Shared system clock, free of runt pulses |
| hold_a | output | 1 | Hold request to processor A, 1 = stop |
| hold_b | output | 1 | Hold request to processor B, 1 = stop |
| b_active | output | 1 | 1 while clock B drives sys_clk |

## Verification
The hardest situation to reach is a request that changes again while a swap is still bridging. Here the first stage holds one value, the second stage holds the other, and the forced hold rises and falls in the middle of a clock phase. The stimulus reaches this by toggling `sel_b` after pseudo-random gaps as short as one eighth of a system clock period. The two input clocks have a 4:7 period ratio and an offset, so the swap edge lands at every relative phase. A behavioural model predicts every output every 500 ps, and an edge monitor measures each phase of `sys_clk`.

// File: rtl/cpuswap_pkg.sv
package cpuswap_pkg;

    localparam int NUM_CPU = 2;

    typedef enum logic [1:0] {
        PH_RUN_A       = 2'b00,
        PH_BRIDGE_TO_B = 2'b10,
        PH_BRIDGE_TO_A = 2'b01,
        PH_RUN_B       = 2'b11
    } swap_phase_e;

    function automatic swap_phase_e phase_of(input logic committed, input logic confirmed);
        swap_phase_e ph;
        unique case ({committed, confirmed})
            2'b00:   ph = PH_RUN_A;
            2'b10:   ph = PH_BRIDGE_TO_B;
            2'b01:   ph = PH_BRIDGE_TO_A;
            default: ph = PH_RUN_B;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/cs_req_sync.sv
// Two-stage capture of the processor request on the outgoing system clock.
module cs_req_sync (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic sel_req,
    output logic stage2
);
    logic stage1_q, stage2_q;

    // State register
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= sel_req;
            stage2_q <= stage1_q;
        end
    end

    // Outputs
    always_comb begin
        stage2 = stage2_q;
    end
endmodule

// File: rtl/cs_clk_gate.sv
// Third stage on the newly selected clock and the output gate.
module cs_clk_gate
    import cpuswap_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic stage2,
    output logic stage3,
    output logic sys_clk
);
    logic        pick_clk;
    logic        stage3_q;
    swap_phase_e phase;

    // Clock chosen by the committed selection; only its rising edges move stage 3
    always_comb begin
        pick_clk = stage2 ? clk_b : clk_a;
    end

    // State register
    always_ff @(posedge pick_clk or negedge rst_n) begin
        if (!rst_n) stage3_q <= 1'b0;
        else        stage3_q <= stage2;
    end

    // Outputs: phase and gated clock in one process, so no transient value appears
    always_comb begin
        phase = phase_of(stage2, stage3_q);
        unique case (phase)
            PH_RUN_A:       sys_clk = clk_a;
            PH_RUN_B:       sys_clk = clk_b;
            PH_BRIDGE_TO_B: sys_clk = 1'b1;
            PH_BRIDGE_TO_A: sys_clk = 1'b1;
        endcase
        stage3 = stage3_q;
    end
endmodule

// File: rtl/cs_hold_seq.sv
// Hold request per processor: forced high during a swap, released on its own clock.
module cs_hold_seq
    import cpuswap_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_req,
    input  logic stage2,
    output logic hold_a,
    output logic hold_b
);
    logic [NUM_CPU-1:0] cpu_clk;
    logic [NUM_CPU-1:0] hold_vec;
    logic               force_hold;

    always_comb begin
        cpu_clk    = {clk_b, clk_a};
        force_hold = rst_n & (sel_req ^ stage2);
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        localparam logic OWN_CODE = (i != 0);
        logic held_q;

        always_ff @(posedge cpu_clk[i] or posedge force_hold or negedge rst_n) begin
            if (!rst_n)          held_q <= OWN_CODE;
            else if (force_hold) held_q <= 1'b1;
            else                 held_q <= (stage2 != OWN_CODE);
        end

        assign hold_vec[i] = held_q;
    end

    always_comb begin
        hold_a = hold_vec[0];
        hold_b = hold_vec[1];
    end
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_b,
    output logic sys_clk,
    output logic hold_a,
    output logic hold_b,
    output logic b_active
);
    logic stage2;
    logic stage3;

    cs_req_sync u_sync (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .sel_req (sel_b),
        .stage2  (stage2)
    );

    cs_clk_gate u_gate (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .rst_n   (rst_n),
        .stage2  (stage2),
        .stage3  (stage3),
        .sys_clk (sys_clk)
    );

    cs_hold_seq u_hold (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .rst_n   (rst_n),
        .sel_req (sel_b),
        .stage2  (stage2),
        .hold_a  (hold_a),
        .hold_b  (hold_b)
    );

    assign b_active = stage3;
endmodule

// File: rtl/cpu_clk_switch_chk.sv
module cpu_clk_switch_chk (
    input logic clk_a,
    input logic clk_b,
    input logic rst_n,
    input logic sel_b,
    input logic sys_clk,
    input logic hold_a,
    input logic hold_b,
    input logic b_active,
    input logic stage2
);
    AST_SWAP_HOLDS_BOTH_A: assert property (@(posedge clk_a) disable iff (!rst_n)
        (sel_b != stage2) |-> (hold_a && hold_b)); // R5
    AST_SWAP_HOLDS_BOTH_B: assert property (@(posedge clk_b) disable iff (!rst_n)
        (sel_b != stage2) |-> (hold_a && hold_b)); // R5
    AST_NEVER_BOTH_RUN_A: assert property (@(posedge clk_a) disable iff (!rst_n)
        (hold_a || hold_b)); // R6
    AST_NEVER_BOTH_RUN_B: assert property (@(posedge clk_b) disable iff (!rst_n)
        (hold_a || hold_b)); // R6
    AST_IDLE_CPU_STAYS_HELD: assert property (@(posedge clk_a) disable iff (!rst_n)
        (b_active && stage2 && sel_b) |-> hold_a); // R6
    AST_STATUS_RISE: assert property (@(posedge clk_b) disable iff (!rst_n)
        (stage2 && !b_active) |=> b_active); // R7
    AST_STATUS_FALL: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!stage2 && b_active) |=> !b_active); // R8
    AST_BRIDGE_STAYS_HIGH: assert property (@(negedge clk_a) disable iff (!rst_n)
        (stage2 != b_active) |-> sys_clk); // R3
endmodule

bind cpu_clk_switch cpu_clk_switch_chk u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .sel_b    (sel_b),
    .sys_clk  (sys_clk),
    .hold_a   (hold_a),
    .hold_b   (hold_b),
    .b_active (b_active),
    .stage2   (stage2)
);

// File: tb/cpu_clk_switch_tb_top.sv
module cpu_clk_switch_tb_top;
    timeunit 1ps;
    timeprecision 1ps;

    localparam int HALF_A   = 2000;   // 250 MHz
    localparam int HALF_B   = 3500;
    localparam int MIN_HALF = (HALF_A < HALF_B) ? HALF_A : HALF_B;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0, sel_b = 1'b0;
    logic sys_clk, hold_a, hold_b, b_active;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    cpu_clk_switch dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel_b(sel_b),
        .sys_clk(sys_clk), .hold_a(hold_a), .hold_b(hold_b), .b_active(b_active)
    );

    always #HALF_A clk_a = ~clk_a;
    initial begin
        #1250;
        forever #HALF_B clk_b = ~clk_b;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Behavioural reference: request seen, request committed, clock owner
    bit m_seen = 0, m_commit = 0, m_live = 0, m_ha = 0, m_hb = 1;
    wire m_force = rst_n && (sel_b != m_commit);

    always @(posedge clk_a) if (rst_n) begin
        if (!m_live && !m_commit) begin m_seen <= sel_b; m_commit <= m_seen; end
        if (m_live && !m_commit) m_live <= 1'b0;
    end
    always @(posedge clk_b) if (rst_n) begin
        if (m_live && m_commit) begin m_seen <= sel_b; m_commit <= m_seen; end
        if (!m_live && m_commit) m_live <= 1'b1;
    end
    always @(posedge clk_a or posedge m_force)
        if (m_force) m_ha <= 1'b1; else if (rst_n) m_ha <= m_commit;
    always @(posedge clk_b or posedge m_force)
        if (m_force) m_hb <= 1'b1; else if (rst_n) m_hb <= !m_commit;

    // Compare every 500 ps, at instants away from all clock edges
    initial begin
        #400;
        while (!done) begin
            if (rst_n) begin
                bit exp_clk;
                exp_clk = (m_commit != m_live) ? 1'b1 : (m_live ? clk_b : clk_a);
                check(sys_clk == exp_clk, (m_commit != m_live) ? "R3" : "R4", sys_clk, exp_clk);
                check(hold_a == (m_force | m_ha), m_force ? "R5" : "R6", hold_a, m_force | m_ha);
                check(hold_b == (m_force | m_hb), m_force ? "R5" : "R6", hold_b, m_force | m_hb);
                check(b_active == m_live, "R7", b_active, m_live);
            end
            #500;
        end
    end

    // Phase width monitor (R4)
    longint last_edge = -1;
    always @(sys_clk) begin
        if (rst_n && last_edge >= 0)
            check(($time - last_edge) >= MIN_HALF, "R4", $time - last_edge, MIN_HALF);
        last_edge = $time;
    end

    initial begin
        #40_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned lfsr = 32'h1ACE_B00C;
        #20100 rst_n = 1'b1;
        #300;
        check(b_active == 1'b0, "R1", b_active, 0);
        check(hold_a == 1'b0,   "R1", hold_a, 0);
        check(hold_b == 1'b1,   "R1", hold_b, 1);
        check(sys_clk == clk_a, "R1", sys_clk, clk_a);

        #19700 sel_b = 1'b1;
        #200 check(hold_a && hold_b, "R5", {hold_a, hold_b}, 3);
        @(posedge sys_clk);
        #100 check(b_active == 1'b0, "R2", b_active, 0);
        @(posedge sys_clk);
        @(negedge clk_a);
        #100 check(b_active ? (sys_clk == clk_b) : (sys_clk == 1'b1), "R2", sys_clk, 1);

        #(200_000 - ($time % 500) + 100);
        check(b_active == 1'b1, "R7", b_active, 1);
        check(hold_a == 1'b1,   "R6", hold_a, 1);
        check(hold_b == 1'b0,   "R6", hold_b, 0);

        sel_b = 1'b0;
        #200_000;
        check(b_active == 1'b0, "R8", b_active, 0);
        check(hold_a == 1'b0,   "R8", hold_a, 0);
        check(hold_b == 1'b1,   "R8", hold_b, 1);

        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3] || lfsr[9]) sel_b = ~sel_b;
            #(500 * (1 + (lfsr[15:8] % 40)));
        end
        sel_b = 1'b0;
        #200_000;
        check(b_active == 1'b0 && hold_b == 1'b1 && hold_a == 1'b0, "R8",
              {b_active, hold_a, hold_b}, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule